// File: doc/BRIEF.md
# Accumulator ALU with Skip Outputs

This block is the arithmetic and logic stage of a small 8-bit accumulator machine. Each cycle it is handed an operation code, the current accumulator and one operand that has already been fetched. While the execute strobe is high, it returns the new accumulator value with a write enable and a skip request for the instruction that follows. It also returns the next carry and half-carry values, each with its own write enable.

The carry and half-carry flags are held in registers inside the block and load at the clock edge. The next-state values are also driven combinationally, so a surrounding core can forward them. The machine has no zero, sign or overflow flags: compares and carry tests raise the skip request instead.

The low three bits of the operation code carry the two-operand field that the instruction decoder passes through unchanged. The codes above 7 select the single-operand operations and the carry operations. Operand fetch and instruction decode are outside this block.

Top module: `acc_alu`

## Requirements
- R1: Code 0 (add with carry) gives {C,A} = A + operand + C. The half-carry becomes the carry out of bit 3. The accumulator, C and H are all written.
- R2: Code 1 (subtract with carry) gives {C,A} = A + ~operand + C, so C=1 after the operation means no borrow occurred. H is the carry out of bit 3 of that same sum. The accumulator, C and H are all written.
- R3: Code 2 requests a skip when A differs from the operand. Code 3 requests a skip when A ≤ operand, compared as unsigned values. Neither code writes the accumulator or any flag.
- R4: Code 4 gives A + operand, code 8 gives A + 1 and code 9 gives A − 1, all modulo 256. None of these three writes C or H.
- R5: Codes 5, 6 and 7 give A AND, XOR and OR operand respectively. None of them writes a flag.
- R6: Code 10 rotates left through carry: A becomes {A[6:0],C} and C becomes the old A[7]. Code 11 rotates right through carry: A becomes {C,A[7:1]} and C becomes the old A[0]. H is not written by either.
- R7: Code 12 exchanges A[7:4] with A[3:0] and writes no flag.
- R8: Code 13 is the decimal correction.
  - It first adds 0x06 when H=1 or A[3:0] > 9.
  - It then adds 0x60 when C=1 or the intermediate value exceeds 0x99.
  - C becomes 1 when that second step applies; otherwise C is unchanged. H is not written.
- R9: Code 14 requests a skip when C=0 and code 15 requests a skip when C=1. Codes 16 and 17 write C to 0 and 1 respectively. None of these four codes writes the accumulator.
- R10: When exec_i is low, or when the code is in the range 18 to 31, every write enable and the skip request are 0, and the stored flags keep their values across the clock edge.
- R11: While rst_n is low, the stored C and H are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| exec_i | input | 1 | Execute strobe; the operation takes effect this cycle |
| op_i | input | 5 | Operation code (see requirements) |
| acc_i | input | DATA_W | Current accumulator |
| opnd_i | input | DATA_W | Fetched operand |
| acc_o | output | DATA_W | New accumulator value |
| acc_we_o | output | 1 | Accumulator write enable |
| skip_o | output | 1 | Skip the next instruction |
| carry_o | output | 1 | Next carry value |
| carry_we_o | output | 1 | Carry write enable |
| hc_o | output | 1 | Next half-carry value |
| hc_we_o | output | 1 | Half-carry write enable |
| carry_q_o | output | 1 | Stored carry |
| hc_q_o | output | 1 | Stored half-carry |

## Verification
The bench builds the block with DATA_W = 8, the only width at which the decimal correction and the nibble swap are defined. At this width every wrap-around boundary can be reached directly: 0xFF + 1, 0x00 − 1, and the carry chain passing through bit 3 into bit 7. Random codes cover the whole 5-bit space, including the unassigned codes, and the execute strobe is dropped often. A running model of C and H therefore checks that the flags are held exactly when no write is expected. Directed cases cover the decimal adjust around 0x99, equal compares, and a reset applied while the flags are set.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADC      = 5'd0,
        OP_SUBC     = 5'd1,
        OP_CMPNE    = 5'd2,
        OP_CMPGT    = 5'd3,
        OP_ADD      = 5'd4,
        OP_AND      = 5'd5,
        OP_XOR      = 5'd6,
        OP_OR       = 5'd7,
        OP_INC      = 5'd8,
        OP_DEC      = 5'd9,
        OP_ROTL     = 5'd10,
        OP_ROTR     = 5'd11,
        OP_SWAP     = 5'd12,
        OP_DECADJ   = 5'd13,
        OP_SKIP_CLR = 5'd14,
        OP_SKIP_SET = 5'd15,
        OP_CLRC     = 5'd16,
        OP_SETC     = 5'd17
    } alu_op_e;

    typedef struct packed {
        logic c;
        logic h;
    } flags_t;

endpackage

// File: rtl/acc_alu_adder.sv
module acc_alu_adder #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cin_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              cout_o,
    output logic              hout_o
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W:0] full;
    logic [HALF_W:0] low;

    always_comb begin
        full   = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_i};
        low    = {1'b0, a_i[HALF_W-1:0]} + {1'b0, b_i[HALF_W-1:0]}
               + {{HALF_W{1'b0}}, cin_i};
        sum_o  = full[DATA_W-1:0];
        cout_o = full[DATA_W];
        hout_o = low[HALF_W];
    end
endmodule

// File: rtl/acc_alu_bitops.sv
module acc_alu_bitops
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              c_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cout_o
);
    localparam int HALF_W = DATA_W / 2;

    always_comb begin
        res_o  = a_i;
        cout_o = c_i;
        unique case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_ROTL: begin
                res_o  = {a_i[DATA_W-2:0], c_i};
                cout_o = a_i[DATA_W-1];
            end
            OP_ROTR: begin
                res_o  = {c_i, a_i[DATA_W-1:1]};
                cout_o = a_i[0];
            end
            OP_SWAP: res_o = {a_i[HALF_W-1:0], a_i[DATA_W-1:HALF_W]};
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_alu_decadj.sv
module acc_alu_decadj #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic              c_i,
    input  logic              h_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cout_o
);
    localparam int DIGIT_W = 4;
    localparam logic [DATA_W:0] LO_FIX  = (DATA_W+1)'(6);
    localparam logic [DATA_W:0] HI_FIX  = (DATA_W+1)'(6) << DIGIT_W;
    localparam logic [DATA_W:0] HI_LIM  = (DATA_W+1)'(9 * 16 + 9);

    logic [DATA_W:0] stage1;
    logic [DATA_W:0] stage2;
    logic            lo_adj;
    logic            hi_adj;

    always_comb begin
        lo_adj = h_i || (a_i[DIGIT_W-1:0] > 4'd9);
        stage1 = {1'b0, a_i} + (lo_adj ? LO_FIX : '0);
        hi_adj = c_i || (stage1 > HI_LIM);
        stage2 = stage1 + (hi_adj ? HI_FIX : '0);
        res_o  = stage2[DATA_W-1:0];
        cout_o = hi_adj;
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_i,
    input  logic [4:0]        op_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] opnd_i,
    output logic [DATA_W-1:0] acc_o,
    output logic              acc_we_o,
    output logic              skip_o,
    output logic              carry_o,
    output logic              carry_we_o,
    output logic              hc_o,
    output logic              hc_we_o,
    output logic              carry_q_o,
    output logic              hc_q_o
);
    alu_op_e op;
    flags_t  flags_d, flags_q;

    logic [DATA_W-1:0] add_b;
    logic              add_cin;
    logic [DATA_W-1:0] add_sum;
    logic              add_cout, add_hout;
    logic [DATA_W-1:0] bit_res;
    logic              bit_cout;
    logic [DATA_W-1:0] dec_res;
    logic              dec_cout;

    logic [DATA_W-1:0] acc_d;
    logic              acc_we_d, skip_d, c_d, c_we_d, h_d, h_we_d;

    assign op = alu_op_e'(op_i);

    // Operand selection for the single shared adder
    always_comb begin
        add_b   = opnd_i;
        add_cin = 1'b0;
        unique case (op)
            OP_ADC:  add_cin = flags_q.c;
            OP_SUBC: begin
                add_b   = ~opnd_i;
                add_cin = flags_q.c;
            end
            OP_INC:  begin
                add_b   = '0;
                add_cin = 1'b1;
            end
            OP_DEC:  add_b = '1;
            default: ;
        endcase
    end

    acc_alu_adder #(.DATA_W(DATA_W)) u_adder (
        .a_i    (acc_i),
        .b_i    (add_b),
        .cin_i  (add_cin),
        .sum_o  (add_sum),
        .cout_o (add_cout),
        .hout_o (add_hout)
    );

    acc_alu_bitops #(.DATA_W(DATA_W)) u_bitops (
        .op_i   (op),
        .a_i    (acc_i),
        .b_i    (opnd_i),
        .c_i    (flags_q.c),
        .res_o  (bit_res),
        .cout_o (bit_cout)
    );

    acc_alu_decadj #(.DATA_W(DATA_W)) u_decadj (
        .a_i    (acc_i),
        .c_i    (flags_q.c),
        .h_i    (flags_q.h),
        .res_o  (dec_res),
        .cout_o (dec_cout)
    );

    // Next-value computation
    always_comb begin
        acc_d    = acc_i;
        acc_we_d = 1'b0;
        skip_d   = 1'b0;
        c_d      = flags_q.c;
        c_we_d   = 1'b0;
        h_d      = flags_q.h;
        h_we_d   = 1'b0;
        unique case (op)
            OP_ADC, OP_SUBC: begin
                acc_d    = add_sum;
                acc_we_d = 1'b1;
                c_d      = add_cout;
                c_we_d   = 1'b1;
                h_d      = add_hout;
                h_we_d   = 1'b1;
            end
            OP_ADD, OP_INC, OP_DEC: begin
                acc_d    = add_sum;
                acc_we_d = 1'b1;
            end
            OP_CMPNE: skip_d = (acc_i != opnd_i);
            OP_CMPGT: skip_d = (acc_i <= opnd_i);
            OP_AND, OP_XOR, OP_OR, OP_SWAP: begin
                acc_d    = bit_res;
                acc_we_d = 1'b1;
            end
            OP_ROTL, OP_ROTR: begin
                acc_d    = bit_res;
                acc_we_d = 1'b1;
                c_d      = bit_cout;
                c_we_d   = 1'b1;
            end
            OP_DECADJ: begin
                acc_d    = dec_res;
                acc_we_d = 1'b1;
                c_d      = dec_cout;
                c_we_d   = 1'b1;
            end
            OP_SKIP_CLR: skip_d = ~flags_q.c;
            OP_SKIP_SET: skip_d = flags_q.c;
            OP_CLRC: begin
                c_d    = 1'b0;
                c_we_d = 1'b1;
            end
            OP_SETC: begin
                c_d    = 1'b1;
                c_we_d = 1'b1;
            end
            default: ;
        endcase

        if (!exec_i) begin
            acc_we_d = 1'b0;
            skip_d   = 1'b0;
            c_we_d   = 1'b0;
            h_we_d   = 1'b0;
        end

        flags_d.c = c_we_d ? c_d : flags_q.c;
        flags_d.h = h_we_d ? h_d : flags_q.h;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign acc_o      = acc_d;
    assign acc_we_o   = acc_we_d;
    assign skip_o     = skip_d;
    assign carry_o    = c_d;
    assign carry_we_o = c_we_d;
    assign hc_o       = h_d;
    assign hc_we_o    = h_we_d;
    assign carry_q_o  = flags_q.c;
    assign hc_q_o     = flags_q.h;

    // A carry write lands in the stored flag at the next edge
    p_carry_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && carry_we_o) |=> (carry_q_o == $past(carry_o)));

    // Compares leave accumulator and flags alone
    p_cmp_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && (op_i == OP_CMPNE || op_i == OP_CMPGT))
            |-> (!acc_we_o && !carry_we_o && !hc_we_o));

    // Plain add, increment and decrement keep the stored carry
    p_plain_keeps_c_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && (op_i == OP_ADD || op_i == OP_INC || op_i == OP_DEC))
            |=> $stable(carry_q_o));

    // Skip-if-carry-clear follows the stored carry
    p_skip_cclr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && op_i == OP_SKIP_CLR) |-> (skip_o == !carry_q_o));

    // Idle cycles hold both flags
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_i |=> ($stable(carry_q_o) && $stable(hc_q_o)));

    // Reset holds both flags at zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_reset_clear_r11: assert (!carry_q_o && !hc_q_o);
        end
    end
endmodule

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         exec_i = 1'b0;
    logic [4:0]   op_i = '0;
    logic [W-1:0] acc_i = '0, opnd_i = '0;
    logic [W-1:0] acc_o;
    logic acc_we_o, skip_o, carry_o, carry_we_o, hc_o, hc_we_o, carry_q_o, hc_q_o;

    int total = 0;
    int bad = 0;
    logic mc = 1'b0;
    logic mh = 1'b0;

    always #2 clk = ~clk;

    acc_alu #(.DATA_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .op_i(op_i),
        .acc_i(acc_i), .opnd_i(opnd_i), .acc_o(acc_o), .acc_we_o(acc_we_o),
        .skip_o(skip_o), .carry_o(carry_o), .carry_we_o(carry_we_o),
        .hc_o(hc_o), .hc_we_o(hc_we_o), .carry_q_o(carry_q_o), .hc_q_o(hc_q_o)
    );

    function automatic string req_of(input logic [4:0] op, input logic ex);
        if (!ex || op > 5'd17) return "R10";
        case (op)
            5'd0: return "R1";
            5'd1: return "R2";
            5'd2, 5'd3: return "R3";
            5'd4, 5'd8, 5'd9: return "R4";
            5'd5, 5'd6, 5'd7: return "R5";
            5'd10, 5'd11: return "R6";
            5'd12: return "R7";
            5'd13: return "R8";
            default: return "R9";
        endcase
    endfunction

    function automatic void model(input logic [4:0] op, input logic [7:0] a, b,
                                  input logic c, h, output logic [7:0] r,
                                  output logic awe, sk, nc, nh);
        int s;
        r = a; awe = 1'b0; sk = 1'b0; nc = c; nh = h;
        case (op)
            5'd0, 5'd1: begin
                s  = (op == 5'd0) ? 32'(b) : 32'(~b & 8'hFF);
                nh = (((a & 8'h0F) + (s & 15) + int'(c)) > 15);
                s  = int'(a) + s + int'(c);
                r = s[7:0]; nc = (s > 255); awe = 1'b1;
            end
            5'd2: sk = (a != b);
            5'd3: sk = (a <= b);
            5'd4: begin r = a + b; awe = 1'b1; end
            5'd5: begin r = a & b; awe = 1'b1; end
            5'd6: begin r = a ^ b; awe = 1'b1; end
            5'd7: begin r = a | b; awe = 1'b1; end
            5'd8: begin r = a + 8'd1; awe = 1'b1; end
            5'd9: begin r = a - 8'd1; awe = 1'b1; end
            5'd10: begin r = {a[6:0], c}; nc = a[7]; awe = 1'b1; end
            5'd11: begin r = {c, a[7:1]}; nc = a[0]; awe = 1'b1; end
            5'd12: begin r = {a[3:0], a[7:4]}; awe = 1'b1; end
            5'd13: begin
                s = int'(a);
                if (h || (a & 8'h0F) > 9) s = s + 6;
                if (c || s > 153) begin s = s + 96; nc = 1'b1; end
                r = s[7:0]; awe = 1'b1;
            end
            5'd14: sk = !c;
            5'd15: sk = c;
            5'd16: nc = 1'b0;
            5'd17: nc = 1'b1;
            default: ;
        endcase
    endfunction

    task automatic step(input logic [4:0] op, input logic [7:0] a, b, input logic ex);
        logic [7:0] r;
        logic awe, sk, nc, nh, ok;
        @(negedge clk);
        op_i = op; acc_i = a; opnd_i = b; exec_i = ex;
        #1;
        model(op, a, b, mc, mh, r, awe, sk, nc, nh);
        if (!ex) begin awe = 1'b0; sk = 1'b0; nc = mc; nh = mh; end
        ok = (acc_we_o == awe) && (skip_o == sk) && (carry_q_o == mc) && (hc_q_o == mh)
             && (!awe || acc_o == r);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s op=%0d a=%h b=%h ex=%0b: acc=%h we=%0b skip=%0b cq=%0b hq=%0b expected acc=%h we=%0b skip=%0b cq=%0b hq=%0b",
                     req_of(op, ex), op, a, b, ex, acc_o, acc_we_o, skip_o, carry_q_o, hc_q_o,
                     r, awe, sk, mc, mh);
        end
        @(posedge clk);
        mc = nc; mh = nh;
    endtask

    task automatic check_flags(input string req, input logic ec, eh);
        @(negedge clk); exec_i = 1'b0; #1;
        total++;
        if (carry_q_o !== ec || hc_q_o !== eh) begin
            bad++;
            $display("FAIL %s flags: c=%0b h=%0b expected c=%0b h=%0b", req, carry_q_o, hc_q_o, ec, eh);
        end
    endtask

    initial begin
        #400000;
        bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        check_flags("R11", 1'b0, 1'b0);     // R11 reset state
        @(negedge clk); rst_n = 1'b1;

        step(5'd17, 8'h00, 8'h00, 1'b1);    // R9 set carry
        step(5'd0, 8'hFF, 8'h00, 1'b1);     // R1 0xFF+0+1 -> 0x00, C=1, H=1
        step(5'd1, 8'h10, 8'h01, 1'b1);     // R2 borrow out of low nibble
        step(5'd1, 8'h00, 8'h01, 1'b1);     // R2 full borrow, C=0
        step(5'd16, 8'h00, 8'h00, 1'b1);    // R9 clear carry
        step(5'd0, 8'h09, 8'h08, 1'b1);     // R1 BCD 9+8 with H=1
        step(5'd13, 8'h11, 8'h00, 1'b1);    // R8 -> 0x17
        step(5'd16, 8'h00, 8'h00, 1'b1);
        step(5'd0, 8'h99, 8'h01, 1'b1);     // R1
        step(5'd13, 8'h9A, 8'h00, 1'b1);    // R8 -> 0x00, C=1
        step(5'd2, 8'h5A, 8'h5A, 1'b1);     // R3 equal, no skip
        step(5'd3, 8'h5A, 8'h5A, 1'b1);     // R3 equal, skip
        step(5'd3, 8'h5B, 8'h5A, 1'b1);     // R3 greater, no skip
        step(5'd4, 8'hFF, 8'h02, 1'b1);     // R4 wrap, carry kept
        step(5'd8, 8'hFF, 8'h00, 1'b1);     // R4 inc wrap
        step(5'd9, 8'h00, 8'h00, 1'b1);     // R4 dec wrap
        step(5'd10, 8'h80, 8'h00, 1'b1);    // R6
        step(5'd11, 8'h01, 8'h00, 1'b1);    // R6
        step(5'd12, 8'hA5, 8'h00, 1'b1);    // R7
        step(5'd16, 8'h00, 8'h00, 1'b0);    // R10 idle clear ignored
        step(5'd31, 8'h12, 8'h34, 1'b1);    // R10 unassigned code
        step(5'd14, 8'h00, 8'h00, 1'b1);    // R9
        step(5'd15, 8'h00, 8'h00, 1'b1);    // R9

        for (int i = 0; i < 4000; i++) begin
            step(5'($urandom % 32), 8'($urandom), 8'($urandom), ($urandom % 8) != 0);
        end

        step(5'd17, 8'h00, 8'h00, 1'b1);
        step(5'd0, 8'h0F, 8'h01, 1'b1);     // sets H
        @(negedge clk); rst_n = 1'b0; #1;
        mc = 1'b0; mh = 1'b0;
        check_flags("R11", 1'b0, 1'b0);     // R11 reset mid-run
        @(negedge clk); rst_n = 1'b1;
        step(5'd5, 8'hF0, 8'h3C, 1'b1);     // R5

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule